// File: doc/BRIEF.md
# Shift and Rotate Unit

A multi-cycle unit that performs logical shifts and rotations on 36-bit words. It works either on one word or on a high/low pair that forms a 72-bit value. The shift distance is a signed 18-bit count. The sign of the count sets the direction. Any magnitude is accepted, up to the full range of the count.

The unit does not run a barrel shifter as wide as the largest count. Instead, while the count is outside the range that one barrel pass can cover, the unit spends one cycle per 36 places. Each such cycle does one of two things. A logical operation moves a whole word across and zero-fills the vacated word. A rotation swaps the two words. The count is adjusted by 36 each time. One barrel pass of at most 36 places then finishes the operation, and the result is registered on the outputs with a one-cycle `done` pulse.

A caller raises `start` for one cycle with `mode`, `count` and the data. The caller then waits for `done`. While the unit is busy, further `start` requests are dropped. No status flags are produced.

Top module: `shrot_unit`

## Requirements
- R1: `count` is an 18-bit two's-complement value. A set bit 17 (negative) selects a right operation. A clear bit 17 selects a left operation by `count` places.
- R2: Single-word logical mode (`mode` = 2'b00) shifts `hi_in` and fills the vacated positions with zeros. A magnitude of 36 or more in either direction gives an all-zero `hi_out`.
- R3: Single-word rotate mode (`mode` = 2'b01) rotates `hi_in` by the count modulo 36. In both single-word modes `lo_out` is zero.
- R4: Combined logical mode (`mode` = 2'b10) shifts the 72-bit value {`hi_in`,`lo_in`} with zero fill; `hi_in` is the high-order half. A magnitude of 72 or more gives zero in both words.
- R5: Combined rotate mode (`mode` = 2'b11) rotates {`hi_in`,`lo_in`} by the count modulo 72.
- R6: `done` rises 1+S cycles after the clock edge that accepts `start`. S counts the 36-place adjustments. For a left count c, S = floor(c/36). For a right count of magnitude m, S = floor((m-1)/36). A rotate with count from -36 to 35 therefore completes with S = 0.
- R7: `busy` is high from the cycle after acceptance until the last cycle before `done`. `done` lasts exactly one cycle, and `busy` is low while `done` is high.
- R8: A `start` raised while `busy` is high is ignored. It does not change the result of the running operation, and it does not begin a new one.
- R9: After reset, `busy`, `done`, `hi_out` and `lo_out` are all zero.
- R10: `hi_out` and `lo_out` change only in the cycle in which `done` is high, and otherwise hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin an operation; accepted only while idle |
| mode | input | 2 | Bit 1: combined 72-bit pair; bit 0: rotate instead of logical shift |
| count | input | 18 | Signed shift count; negative selects right |
| hi_in | input | 36 | Single-word operand, or high half of the pair |
| lo_in | input | 36 | Low half of the pair; unused in single-word modes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse marking a new result |
| hi_out | output | 36 | Result word, or high half of the pair result |
| lo_out | output | 36 | Low half of the pair result; zero in single-word modes |

## Verification
A result is due 1+S cycles after the accepting edge. S is zero for counts inside the barrel range, and grows by one for every further 36 places. Long counts at the top of the 18-bit range therefore take about 3,640 cycles. The bench derives S from the count on its own and counts falling edges after the accepting edge. It requires `busy` on the first of those edges and `done` on exactly edge 1+S, compares both output words there, and then checks one edge later that `done` has dropped and the outputs have held. Requests injected during the busy window are checked by confirming that the due result and its timing belong to the first operation, and that no second `done` follows.

// File: rtl/shrot_pkg.sv
// Shared types for the shift and rotate unit.
// Assumes: the mode port is packed as {combined, rotate}.
package shrot_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } shr_state_e;

    typedef struct packed {
        logic comb;   // operate on the 72-bit high/low pair
        logic rot;    // rotate instead of logical shift
    } shr_mode_t;

endpackage

// File: rtl/shrot_ctrl.sv
// Sequencer and count normaliser for the shift and rotate unit.
// The unit accepts a request only while idle. Each cycle it then decides:
// either the remaining count fits a single barrel pass (left 0..W-1,
// right 0..W) and the unit finishes, or it orders one W-place word step and
// moves the count W places toward zero.
// Assumes: count_in is two's complement, CW bits wide, sampled on load.
module shrot_ctrl #(
    parameter int W  = 36,
    parameter int CW = 18,
    localparam int AMT_W = $clog2(W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CW-1:0]        count_in,
    output logic                 busy,
    output logic                 load,
    output logic                 step,
    output logic                 finish,
    output logic                 right,
    output logic [AMT_W-1:0]     amt
);
    import shrot_pkg::*;

    shr_state_e               state_q;
    logic signed [CW-1:0]     cnt_q;
    logic                     right_q;
    logic                     in_range;
    int                       mag;

    // Range test and barrel amount from the remaining count.
    always_comb begin
        mag      = right_q ? -int'(cnt_q) : int'(cnt_q);
        in_range = right_q ? (int'(cnt_q) >= -W) : (int'(cnt_q) <= W - 1);
        amt      = AMT_W'(mag);
    end

    // Decode this cycle's action from the state and range test.
    always_comb begin
        load   = (state_q == ST_IDLE) && start;
        step   = (state_q == ST_RUN) && !in_range;
        finish = (state_q == ST_RUN) && in_range;
    end

    assign busy  = (state_q == ST_RUN);
    assign right = right_q;

    // State, direction and remaining count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            right_q <= 1'b0;
        end else if (load) begin
            state_q <= ST_RUN;
            cnt_q   <= $signed(count_in);
            right_q <= count_in[CW-1];
        end else if (step) begin
            cnt_q   <= right_q ? cnt_q + $signed(CW'(W)) : cnt_q - $signed(CW'(W));
        end else if (finish) begin
            state_q <= ST_IDLE;
        end
    end

endmodule

// File: rtl/shrot_wordstep.sv
// One W-place adjustment of the operand words, purely combinational.
// Combined logical: a whole word moves across and the vacated word is zeroed.
// Combined rotate: the words swap. Single logical: the word clears.
// Single rotate: a W-place rotation of one word is the identity.
// Assumes: only used while the remaining count is out of barrel range.
module shrot_wordstep #(
    parameter int W = 36
) (
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] lo_i,
    input  logic         comb_i,
    input  logic         rot_i,
    input  logic         right_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);

    // Select the next word pair for the current mode and direction.
    always_comb begin
        hi_o = hi_i;
        lo_o = lo_i;
        if (comb_i) begin
            if (rot_i) begin
                hi_o = lo_i;
                lo_o = hi_i;
            end else if (right_i) begin
                hi_o = '0;
                lo_o = hi_i;
            end else begin
                hi_o = lo_i;
                lo_o = '0;
            end
        end else if (!rot_i) begin
            hi_o = '0;
        end
    end

endmodule

// File: rtl/shrot_barrel.sv
// Final barrel pass of 0..W places, left or right, logical or rotate,
// over one word or the 2W-bit pair.
// Single-word results come out on hi_o, with lo_o forced to zero.
// Assumes: amt_i never exceeds W.
module shrot_barrel #(
    parameter int W = 36,
    localparam int AMT_W = $clog2(W + 1),
    localparam int DW = 2 * W
) (
    input  logic [W-1:0]     hi_i,
    input  logic [W-1:0]     lo_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             comb_i,
    input  logic             rot_i,
    input  logic             right_i,
    output logic [W-1:0]     hi_o,
    output logic [W-1:0]     lo_o
);

    logic [DW-1:0] pair, pair_res;
    logic [W-1:0]  word_res;
    int            a;

    // Pair-width shift or rotation.
    always_comb begin
        a    = int'(amt_i);
        pair = {hi_i, lo_i};
        if (right_i) begin
            pair_res = pair >> a;
            if (rot_i) pair_res = pair_res | (pair << (DW - a));
        end else begin
            pair_res = pair << a;
            if (rot_i) pair_res = pair_res | (pair >> (DW - a));
        end
    end

    // Word-width shift or rotation.
    always_comb begin
        if (right_i) begin
            word_res = hi_i >> a;
            if (rot_i) word_res = word_res | (hi_i << (W - a));
        end else begin
            word_res = hi_i << a;
            if (rot_i) word_res = word_res | (hi_i >> (W - a));
        end
    end

    // Route the result for the chosen width.
    always_comb begin
        if (comb_i) begin
            hi_o = pair_res[DW-1:W];
            lo_o = pair_res[W-1:0];
        end else begin
            hi_o = word_res;
            lo_o = '0;
        end
    end

endmodule

// File: rtl/shrot_unit.sv
// Multi-cycle logical shift and rotate unit for W-bit words and 2W-bit pairs.
// A request is latched, the count is normalised by W-place word steps (one
// per cycle), then a single barrel pass writes the registered result and
// pulses done.
// Assumes: start is a level sampled on the rising edge; the caller holds
// no expectation of the outputs until done.
module shrot_unit #(
    parameter int W  = 36,
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic [CW-1:0] count,
    input  logic [W-1:0]  hi_in,
    input  logic [W-1:0]  lo_in,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  hi_out,
    output logic [W-1:0]  lo_out
);
    import shrot_pkg::*;

    localparam int AMT_W = $clog2(W + 1);

    logic             load, step, finish, right;
    logic [AMT_W-1:0] amt;
    shr_mode_t        mode_q;
    logic [W-1:0]     hi_q, lo_q;
    logic [W-1:0]     hi_step, lo_step;
    logic [W-1:0]     hi_res, lo_res;

    shrot_ctrl #(.W(W), .CW(CW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .count_in (count),
        .busy     (busy),
        .load     (load),
        .step     (step),
        .finish   (finish),
        .right    (right),
        .amt      (amt)
    );

    shrot_wordstep #(.W(W)) u_step (
        .hi_i    (hi_q),
        .lo_i    (lo_q),
        .comb_i  (mode_q.comb),
        .rot_i   (mode_q.rot),
        .right_i (right),
        .hi_o    (hi_step),
        .lo_o    (lo_step)
    );

    shrot_barrel #(.W(W)) u_barrel (
        .hi_i    (hi_q),
        .lo_i    (lo_q),
        .amt_i   (amt),
        .comb_i  (mode_q.comb),
        .rot_i   (mode_q.rot),
        .right_i (right),
        .hi_o    (hi_res),
        .lo_o    (lo_res)
    );

    // Operand and mode registers: loaded on accept, updated on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            mode_q <= '0;
        end else if (load) begin
            hi_q   <= hi_in;
            lo_q   <= lo_in;
            mode_q <= shr_mode_t'(mode);
        end else if (step) begin
            hi_q   <= hi_step;
            lo_q   <= lo_step;
        end
    end

    // Result registers and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_out <= '0;
            lo_out <= '0;
            done   <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                hi_out <= hi_res;
                lo_out <= lo_res;
            end
        end
    end

endmodule

// File: rtl/shrot_unit_chk.sv
// Protocol checker for shrot_unit, attached by bind.
// It watches only the ports and keeps its own record of the accepted width mode.
module shrot_unit_chk #(
    parameter int W = 36
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   mode,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] hi_out,
    input logic [W-1:0] lo_out
);

    logic past_ok;
    logic comb_seen;

    // Marks that at least one cycle out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Records the width mode of the request that was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)              comb_seen <= 1'b0;
        else if (start && !busy) comb_seen <= mode[1];
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_busy_ends_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $fell(busy)) |-> done);

    assert_hold_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !done) |-> ($stable(hi_out) && $stable(lo_out)));

    assert_single_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !comb_seen) |-> (lo_out == '0));

endmodule

bind shrot_unit shrot_unit_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .mode   (mode),
    .busy   (busy),
    .done   (done),
    .hi_out (hi_out),
    .lo_out (lo_out)
);

// File: tb/shrot_unit_bench.sv
// Self-checking bench for shrot_unit: directed corner cases plus seeded
// random requests, checked against a reference model written in the bench.
module shrot_unit_bench;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = '0;
    logic [17:0] count = '0;
    logic [35:0] hi_in = '0;
    logic [35:0] lo_in = '0;
    logic        busy, done;
    logic [35:0] hi_out, lo_out;

    int checks = 0;
    int errors = 0;

    always #(PERIOD / 2) clk = ~clk;

    shrot_unit u_shrot_unit (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .mode   (mode),
        .count  (count),
        .hi_in  (hi_in),
        .lo_in  (lo_in),
        .busy   (busy),
        .done   (done),
        .hi_out (hi_out),
        .lo_out (lo_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference result {hi,lo}; single-word results sit in the high half.
    function automatic logic [71:0] model(input logic [1:0] md, input logic [17:0] cnt,
                                          input logic [35:0] h, input logic [35:0] l);
        int c, m, k;
        bit left;
        logic [71:0] x, r;
        logic [35:0] w, wr;
        c    = int'($signed(cnt));
        left = (c >= 0);
        m    = left ? c : -c;
        if (md[1]) begin
            x = {h, l};
            if (md[0]) begin
                k = m % 72;
                if (!left) k = (72 - k) % 72;
                r = (x << k) | (x >> (72 - k));
            end else if (m >= 72) r = '0;
            else r = left ? (x << m) : (x >> m);
        end else begin
            w = h;
            if (md[0]) begin
                k = m % 36;
                if (!left) k = (36 - k) % 36;
                wr = (w << k) | (w >> (36 - k));
            end else if (m >= 36) wr = '0;
            else wr = left ? (w << m) : (w >> m);
            r = {wr, 36'b0};
        end
        return r;
    endfunction

    function automatic int steps_of(input logic [17:0] cnt);
        int c;
        c = int'($signed(cnt));
        return (c >= 0) ? (c / 36) : ((-c - 1) / 36);
    endfunction

    function automatic string req_of(input logic [1:0] md);
        case (md)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    // Runs one request; poke raises a competing start while busy (R8).
    task automatic run_op(input logic [1:0] md, input logic [17:0] cnt,
                          input logic [35:0] h, input logic [35:0] l,
                          input bit poke, input string req);
        logic [71:0] exp;
        int n, due;
        bit seen;
        exp  = model(md, cnt, h, l);
        due  = 1 + steps_of(cnt);
        seen = 1'b0;
        @(negedge clk);
        mode = md; count = cnt; hi_in = h; lo_in = l; start = 1'b1;
        @(posedge clk);
        n = 0;
        while (!seen && n < 6000) begin
            @(negedge clk);
            if (n == 0) begin
                chk(busy === 1'b1, "R7", "busy after accept", {71'b0, busy}, 72'd1);
                if (poke) begin
                    start = 1'b1; hi_in = ~h; lo_in = ~l; count = 18'd5; mode = ~md;
                end else start = 1'b0;
            end else begin
                start = 1'b0;
            end
            if (done === 1'b1) seen = 1'b1;
            else n++;
        end
        start = 1'b0;
        chk(seen && n == due, "R6", "done cycle", 72'(n), 72'(due));
        chk({hi_out, md[1] ? lo_out : 36'b0} === exp, req, "result", {hi_out, lo_out}, exp);
        if (!md[1]) chk(lo_out === 36'b0, "R3", "single low word", {36'b0, lo_out}, 72'd0);
        chk(busy === 1'b0, "R7", "busy during done", {71'b0, busy}, 72'd0);
        @(negedge clk);
        chk(done === 1'b0, poke ? "R8" : "R7", "done after pulse", {71'b0, done}, 72'd0);
        chk({hi_out, md[1] ? lo_out : 36'b0} === exp, "R10", "hold", {hi_out, lo_out}, exp);
        if (poke) chk(busy === 1'b0, "R8", "no second op", {71'b0, busy}, 72'd0);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [35:0] a, b;
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(busy === 1'b0 && done === 1'b0, "R9", "flags", {70'b0, busy, done}, 72'd0);
        chk({hi_out, lo_out} === 72'd0, "R9", "outputs", {hi_out, lo_out}, 72'd0);

        a = 36'h8_0F0F_1234;
        b = 36'h5_A5A5_0001;
        // R1 / R2: direction and zero fill, single logical
        run_op(2'b00, 18'd0, a, b, 1'b0, "R2");
        run_op(2'b00, 18'd35, a, b, 1'b0, "R2");
        run_op(2'b00, 18'd36, a, b, 1'b0, "R2");
        run_op(2'b00, -18'sd35, a, b, 1'b0, "R1");
        run_op(2'b00, -18'sd36, a, b, 1'b0, "R1");
        run_op(2'b00, -18'sd37, a, b, 1'b0, "R2");
        // R3: single rotate, fast window and long counts
        run_op(2'b01, 18'd35, a, b, 1'b0, "R3");
        run_op(2'b01, -18'sd36, a, b, 1'b0, "R3");
        run_op(2'b01, 18'd36, a, b, 1'b0, "R3");
        run_op(2'b01, -18'sd37, a, b, 1'b0, "R1");
        run_op(2'b01, 18'h1FFFF, a, b, 1'b0, "R3");
        run_op(2'b01, 18'h20000, a, b, 1'b0, "R3");
        // R4: combined logical across the word boundary
        run_op(2'b10, 18'd40, a, b, 1'b0, "R4");
        run_op(2'b10, 18'd71, a, b, 1'b0, "R4");
        run_op(2'b10, 18'd72, a, b, 1'b0, "R4");
        run_op(2'b10, -18'sd72, a, b, 1'b0, "R4");
        run_op(2'b10, -18'sd73, a, b, 1'b0, "R1");
        // R5: combined rotate modulo 72
        run_op(2'b11, 18'd72, a, b, 1'b0, "R5");
        run_op(2'b11, -18'sd1, a, b, 1'b0, "R5");
        run_op(2'b11, 18'd100, a, b, 1'b0, "R5");
        run_op(2'b11, 18'h20000, a, b, 1'b0, "R5");
        // R8: start while busy, short and long operations
        run_op(2'b11, 18'd3, a, b, 1'b1, "R5");
        run_op(2'b10, 18'd150, a, b, 1'b1, "R4");
        run_op(2'b01, -18'sd200, a, b, 1'b1, "R3");

        for (int i = 0; i < 250; i++) begin
            logic [1:0]  md;
            logic [17:0] cn;
            md = 2'($urandom_range(3));
            if (i % 25 == 7) cn = 18'($urandom);
            else cn = 18'(int'($urandom_range(400)) - 200);
            run_op(md, cn, 36'($urandom) ^ {$urandom_range(15), 32'b0},
                   36'($urandom) ^ {$urandom_range(15), 32'b0},
                   (i % 9 == 0), req_of(md));
        end
        finish_run();
    end

endmodule